// File: doc/BRIEF.md
# Paged PHY Control Register File

This block is the software-visible control and status store of a serial-bus physical layer. A simple synchronous register bus reaches sixteen byte-wide locations. The lower eight hold fixed configuration and status registers. The upper eight are a window. A page number and a port number, both held in location 7, choose what the window shows. Page 0 shows the status and control byte pairs of the selected port. Page 1 is a read-only identification page.

The block holds the configuration that the arbitration logic consumes: the gap count, the root hold-off, the port disables, the acceleration enables, the contender bit and the power class. It also turns writes of command bits into a timed long bus reset and a one-cycle short-reset request. It latches events into sticky flags that software clears by writing 1. These events are a loop, an arbitration timeout, a cable power loss, a fault on a port, and a port status change or resume on a port with its interrupt enabled. It drives the link-active bit for self identification. That bit is the register bit gated by the link power input.

Top module: `phy_regfile`

## Requirements
- R1: After reset, location 1 reads 8'hFC (gap count 6'h3F in bits 7:2, long-reset bit 1 and hold-off bit 0 clear). Location 4 holds the power class in bits 7:5 and contender in bit 4, both loaded from the strap inputs, and link-active in bit 3 set to 1. Location 5 and location 7 read 0.
- R2: Location 7 holds the page in bits 2:0 and the port in bits 7:4. With page 0 and an implemented port, location 8 reads {A line state[1:0], B line state[1:0], child, connected, bias, disabled} of that port, MSB first. Location 9 reads {speed[2:0], interrupt enable, fault, 3'b000}. Line states pass through with 00 invalid, 01 one, 10 zero, 11 high impedance. Writing bit 0 of location 8 sets that port's disable output.
- R3: On page 1, location 8 reads the compliance level (1), location 9 reads 0, locations A–C read the vendor ID and D–F read the product ID, each most significant byte first.
- R4: Pages 2–7, window locations A–F of page 0, location 6, and page-0 accesses to a port number at or beyond NUM_PORTS read 0. Writes to them change no state.
- R5: Writing 1 to bit 1 of location 1 raises bus_reset_active for exactly RESET_CYCLES cycles. That bit reads 1 while the reset runs and 0 after it.
- R6: Writing 1 to bit 0 of location 5 makes short_reset_req high for exactly one cycle, the cycle after the write. The bit then reads 0.
- R7: The location-5 flags loop (bit 2), power fail (bit 3), timeout (bit 4) and port event (bit 5), and each port's fault (location 9 bit 3), are cleared by writing 1 to them. Writing 0 leaves them set.
- R8: The power-fail flag sets when cable_pwr falls from 1 to 0. A rise does not set it.
- R9: The port-event flag sets when connected, bias, disabled or fault of a port changes while that port's interrupt enable (location 9 bit 4) is 1. The same change on a port with the enable at 0 does not set it.
- R10: A resume pulse on any port sets the port-event flag only while the resume enable (location 5 bit 1) is 1.
- R11: When an event and a write-one-to-clear of the same flag fall in one cycle, the flag stays set.
- R12: link_active_out is high exactly when the link-active bit is 1 and link_pwr is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| node_id | input | 6 | Physical node ID from self identification |
| is_root | input | 1 | Node is root |
| cable_pwr | input | 1 | Cable power present |
| link_pwr | input | 1 | Link layer powered |
| contender_strap | input | 1 | Reset value of contender |
| pwr_class_strap | input | 3 | Reset value of power class |
| port_connected | input | NUM_PORTS | Per-port filtered connection status |
| port_bias | input | NUM_PORTS | Per-port bias detect |
| port_child | input | NUM_PORTS | Per-port child indication |
| port_astat | input | 2*NUM_PORTS | Per-port A line state |
| port_bstat | input | 2*NUM_PORTS | Per-port B line state |
| port_speed | input | 3*NUM_PORTS | Per-port negotiated speed |
| port_fault_evt | input | NUM_PORTS | Per-port fault pulse |
| port_resume | input | NUM_PORTS | Per-port resume-start pulse |
| loop_evt | input | 1 | Loop detected pulse |
| timeout_evt | input | 1 | Arbitration timeout pulse |
| bus_reset_active | output | 1 | Long bus reset in progress |
| short_reset_req | output | 1 | One-cycle short reset request |
| link_active_out | output | 1 | Link-active bit for self identification |
| gap_count | output | 6 | Configured gap count |
| root_holdoff | output | 1 | Root hold-off request |
| port_disable | output | NUM_PORTS | Per-port disable |
| accel_en | output | 1 | Arbitration acceleration enable |
| multi_en | output | 1 | Multi-speed concatenation enable |
| contender | output | 1 | Contender bit |
| pwr_class | output | 3 | Power class field |

## Verification
The window is read with several page and port combinations: page 0 on an implemented port, page 0 on a port beyond the count, page 1, and unimplemented pages. These separate a correct page decode from one that ignores the port range or the page number. Status changes are applied on a port with its interrupt enabled and on one with it disabled, and resume pulses are applied with and without the resume enable. These show whether events are gated per port. The flags are driven with rising and falling cable power, with write-zero and write-one, and with an event and a clear in the same cycle. These show edge direction, clear semantics and priority. The long reset length is counted cycle by cycle against RESET_CYCLES.

// File: rtl/phy_regfile.sv
module phy_regfile #(
  parameter int NUM_PORTS = 3,
  parameter int RESET_CYCLES = 8159,
  parameter logic [7:0] COMPLIANCE = 8'h01,
  parameter logic [23:0] VENDOR_ID = 24'hA5C301,
  parameter logic [23:0] PRODUCT_ID = 24'h3C5A17
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reg_we,
  input  logic [3:0]             reg_addr,
  input  logic [7:0]             reg_wdata,
  output logic [7:0]             reg_rdata,
  input  logic [5:0]             node_id,
  input  logic                   is_root,
  input  logic                   cable_pwr,
  input  logic                   link_pwr,
  input  logic                   contender_strap,
  input  logic [2:0]             pwr_class_strap,
  input  logic [NUM_PORTS-1:0]   port_connected,
  input  logic [NUM_PORTS-1:0]   port_bias,
  input  logic [NUM_PORTS-1:0]   port_child,
  input  logic [2*NUM_PORTS-1:0] port_astat,
  input  logic [2*NUM_PORTS-1:0] port_bstat,
  input  logic [3*NUM_PORTS-1:0] port_speed,
  input  logic [NUM_PORTS-1:0]   port_fault_evt,
  input  logic [NUM_PORTS-1:0]   port_resume,
  input  logic                   loop_evt,
  input  logic                   timeout_evt,
  output logic                   bus_reset_active,
  output logic                   short_reset_req,
  output logic                   link_active_out,
  output logic [5:0]             gap_count,
  output logic                   root_holdoff,
  output logic [NUM_PORTS-1:0]   port_disable,
  output logic                   accel_en,
  output logic                   multi_en,
  output logic                   contender,
  output logic [2:0]             pwr_class
);
  localparam int CW  = $clog2(RESET_CYCLES + 1);
  localparam int PW  = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
  localparam int NP2 = 1 << PW;

  logic [5:0] gap_q;
  logic       hold_q, la_q, cont_q, sbr_q, res_en_q, accel_q, multi_q;
  logic       loop_q, pf_q, to_q, pe_q, cps_d;
  logic [2:0] pc_q, page_sel;
  logic [3:0] port_sel;
  logic [CW-1:0] rst_cnt;

  logic [NUM_PORTS-1:0] dis_q, ien_q, flt_q, chg, port_hit;
  logic [7:0] stat_rd [NP2];
  logic [7:0] ctl_rd  [NP2];

  wire port_ok = int'(port_sel) < NUM_PORTS;
  wire [PW-1:0] psel = port_sel[PW-1:0];
  wire win_p0 = (page_sel == 3'd0) && port_ok;
  wire wr1 = reg_we && reg_addr == 4'h1;
  wire wr4 = reg_we && reg_addr == 4'h4;
  wire wr5 = reg_we && reg_addr == 4'h5;
  wire wr7 = reg_we && reg_addr == 4'h7;
  wire any_evt = |(chg & ien_q) | (res_en_q & |port_resume);

  assign bus_reset_active = rst_cnt != '0;
  assign short_reset_req  = sbr_q;
  assign link_active_out  = la_q & link_pwr;
  assign gap_count        = gap_q;
  assign root_holdoff     = hold_q;
  assign port_disable     = dis_q;
  assign accel_en         = accel_q;
  assign multi_en         = multi_q;
  assign contender        = cont_q;
  assign pwr_class        = pc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q    <= 6'h3F;
      hold_q   <= 1'b0;
      la_q     <= 1'b1;
      cont_q   <= contender_strap;
      pc_q     <= pwr_class_strap;
      sbr_q    <= 1'b0;
      res_en_q <= 1'b0;
      accel_q  <= 1'b0;
      multi_q  <= 1'b0;
      page_sel <= '0;
      port_sel <= '0;
      rst_cnt  <= '0;
      cps_d    <= 1'b0;
    end else begin
      cps_d <= cable_pwr;
      sbr_q <= wr5 & reg_wdata[0];
      if (wr1) begin
        gap_q  <= reg_wdata[7:2];
        hold_q <= reg_wdata[0];
      end
      if (wr1 && reg_wdata[1]) rst_cnt <= CW'(RESET_CYCLES);
      else if (rst_cnt != '0)  rst_cnt <= rst_cnt - 1'b1;
      if (wr4) begin
        pc_q   <= reg_wdata[7:5];
        cont_q <= reg_wdata[4];
        la_q   <= reg_wdata[3];
      end
      if (wr5) begin
        res_en_q <= reg_wdata[1];
        accel_q  <= reg_wdata[6];
        multi_q  <= reg_wdata[7];
      end
      if (wr7) begin
        page_sel <= reg_wdata[2:0];
        port_sel <= reg_wdata[7:4];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loop_q <= 1'b0;
      pf_q   <= 1'b0;
      to_q   <= 1'b0;
      pe_q   <= 1'b0;
    end else begin
      if (loop_evt) loop_q <= 1'b1;
      else if (wr5 && reg_wdata[2]) loop_q <= 1'b0;
      if (cps_d && !cable_pwr) pf_q <= 1'b1;
      else if (wr5 && reg_wdata[3]) pf_q <= 1'b0;
      if (timeout_evt) to_q <= 1'b1;
      else if (wr5 && reg_wdata[4]) to_q <= 1'b0;
      if (any_evt) pe_q <= 1'b1;
      else if (wr5 && reg_wdata[5]) pe_q <= 1'b0;
    end
  end

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
    logic dis, ien, flt, conn_d, bias_d, dis_d, flt_d;
    assign port_hit[i] = win_p0 && port_sel == 4'(i);
    assign dis_q[i] = dis;
    assign ien_q[i] = ien;
    assign flt_q[i] = flt;
    assign chg[i] = (conn_d != port_connected[i]) | (bias_d != port_bias[i]) |
                    (dis_d != dis) | (flt_d != flt);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dis <= 1'b0; ien <= 1'b0; flt <= 1'b0;
        conn_d <= 1'b0; bias_d <= 1'b0; dis_d <= 1'b0; flt_d <= 1'b0;
      end else begin
        conn_d <= port_connected[i];
        bias_d <= port_bias[i];
        dis_d  <= dis;
        flt_d  <= flt;
        if (port_hit[i] && reg_we && reg_addr == 4'h8) dis <= reg_wdata[0];
        if (port_hit[i] && reg_we && reg_addr == 4'h9) ien <= reg_wdata[4];
        if (port_fault_evt[i]) flt <= 1'b1;
        else if (port_hit[i] && reg_we && reg_addr == 4'h9 && reg_wdata[3]) flt <= 1'b0;
      end
    end
  end

  for (genvar i = 0; i < NP2; i++) begin : g_rd
    if (i < NUM_PORTS) begin : g_real
      assign stat_rd[i] = {port_astat[2*i +: 2], port_bstat[2*i +: 2], port_child[i],
                           port_connected[i], port_bias[i], dis_q[i]};
      assign ctl_rd[i]  = {port_speed[3*i +: 3], ien_q[i], flt_q[i], 3'b000};
    end else begin : g_none
      assign stat_rd[i] = 8'h00;
      assign ctl_rd[i]  = 8'h00;
    end
  end

  always_comb begin
    reg_rdata = 8'h00;
    unique case (reg_addr)
      4'h0: reg_rdata = {node_id, is_root, cable_pwr};
      4'h1: reg_rdata = {gap_q, bus_reset_active, hold_q};
      4'h2: reg_rdata = {3'b111, 5'(NUM_PORTS)};
      4'h3: reg_rdata = 8'h02;
      4'h4: reg_rdata = {pc_q, cont_q, la_q, 3'b000};
      4'h5: reg_rdata = {multi_q, accel_q, pe_q, to_q, pf_q, loop_q, res_en_q, sbr_q};
      4'h6: reg_rdata = 8'h00;
      4'h7: reg_rdata = {port_sel, 1'b0, page_sel};
      default: begin
        if (win_p0) begin
          if (reg_addr == 4'h8) reg_rdata = stat_rd[psel];
          else if (reg_addr == 4'h9) reg_rdata = ctl_rd[psel];
        end else if (page_sel == 3'd1) begin
          case (reg_addr)
            4'h8: reg_rdata = COMPLIANCE;
            4'hA: reg_rdata = VENDOR_ID[23:16];
            4'hB: reg_rdata = VENDOR_ID[15:8];
            4'hC: reg_rdata = VENDOR_ID[7:0];
            4'hD: reg_rdata = PRODUCT_ID[23:16];
            4'hE: reg_rdata = PRODUCT_ID[15:8];
            4'hF: reg_rdata = PRODUCT_ID[7:0];
            default: reg_rdata = 8'h00;
          endcase
        end
      end
    endcase
  end
endmodule

module phy_regfile_chk #(
  parameter logic [7:0] COMPLIANCE = 8'h01
) (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_we,
  input logic [3:0] reg_addr,
  input logic [7:0] reg_wdata,
  input logic [7:0] reg_rdata,
  input logic [2:0] page_sel,
  input logic       cable_pwr,
  input logic       link_pwr,
  input logic       link_active_out,
  input logic       short_reset_req,
  input logic       bus_reset_active,
  input logic       loop_evt,
  input logic       loop_q,
  input logic       pf_q
);
  assert_link_gate_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !link_pwr |-> !link_active_out);
  assert_short_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    short_reset_req |=> !short_reset_req);
  assert_long_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 4'h1 && reg_wdata[1]) |=> bus_reset_active);
  assert_pwr_fail_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $fell(cable_pwr)) |=> pf_q);
  assert_event_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    loop_evt |=> loop_q);
  assert_ident_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (page_sel == 3'd1 && reg_addr == 4'h8) |-> reg_rdata == COMPLIANCE);
  assert_unimpl_page_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (page_sel > 3'd1 && reg_addr[3]) |-> reg_rdata == 8'h00);
endmodule

bind phy_regfile phy_regfile_chk #(.COMPLIANCE(COMPLIANCE)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .page_sel(page_sel),
  .cable_pwr(cable_pwr), .link_pwr(link_pwr), .link_active_out(link_active_out),
  .short_reset_req(short_reset_req), .bus_reset_active(bus_reset_active),
  .loop_evt(loop_evt), .loop_q(loop_q), .pf_q(pf_q)
);

// File: tb/phy_regfile_bench.sv
module phy_regfile_bench;
  localparam int NP = 3;
  localparam int RC = 100;
  localparam logic [23:0] VID = 24'hA5C301;
  localparam logic [23:0] PID = 24'h3C5A17;

  logic clk = 0, rst_n = 0;
  logic reg_we = 0;
  logic [3:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic [5:0] node_id = 6'h05;
  logic is_root = 0, cable_pwr = 1, link_pwr = 1;
  logic contender_strap = 1;
  logic [2:0] pwr_class_strap = 3'b101;
  logic [NP-1:0] port_connected = 0, port_bias = 0, port_child = 0;
  logic [2*NP-1:0] port_astat = 0, port_bstat = 0;
  logic [3*NP-1:0] port_speed = 0;
  logic [NP-1:0] port_fault_evt = 0, port_resume = 0;
  logic loop_evt = 0, timeout_evt = 0;
  logic bus_reset_active, short_reset_req, link_active_out;
  logic [5:0] gap_count;
  logic root_holdoff, accel_en, multi_en, contender;
  logic [NP-1:0] port_disable;
  logic [2:0] pwr_class;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  phy_regfile #(.NUM_PORTS(NP), .RESET_CYCLES(RC), .VENDOR_ID(VID), .PRODUCT_ID(PID))
  u_phy_regfile (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(4'h1, d); check("R1 loc1", d, 8'hFC);
    rd(4'h4, d); check("R1 loc4", d, 8'hB8);
    rd(4'h5, d); check("R1 loc5", d, 8'h00);
    rd(4'h7, d); check("R1 loc7", d, 8'h00);
    check("R1 gap out", gap_count, 6'h3F);
  endtask

  task automatic t_link();
    check("R12 both high", link_active_out, 1'b1);
    link_pwr = 0; #1 check("R12 link_pwr low", link_active_out, 1'b0);
    link_pwr = 1;
    wr(4'h4, 8'hB0);
    check("R12 bit cleared", link_active_out, 1'b0);
    wr(4'h4, 8'hB8);
    check("R12 bit set again", link_active_out, 1'b1);
  endtask

  task automatic t_window();
    logic [7:0] d;
    port_astat = 6'b00_10_00; port_bstat = 6'b00_01_00;
    port_child = 3'b010; port_connected = 3'b010; port_bias = 3'b000;
    port_speed = 9'b000_010_000;
    wr(4'h7, 8'h10);
    rd(4'h8, d); check("R2 port1 status", d, 8'h9C);
    rd(4'h9, d); check("R2 port1 control", d, 8'h40);
    wr(4'h8, 8'h01);
    check("R2 disable port1", port_disable, 3'b010);
    wr(4'h8, 8'h00);
    idle(3);
  endtask

  task automatic t_ident();
    logic [7:0] d;
    wr(4'h7, 8'h01);
    rd(4'h8, d); check("R3 compliance", d, 8'h01);
    rd(4'h9, d); check("R3 reserved", d, 8'h00);
    rd(4'hA, d); check("R3 vendor msb", d, VID[23:16]);
    rd(4'hC, d); check("R3 vendor lsb", d, VID[7:0]);
    rd(4'hD, d); check("R3 product msb", d, PID[23:16]);
    rd(4'hF, d); check("R3 product lsb", d, PID[7:0]);
  endtask

  task automatic t_unimpl();
    logic [7:0] d;
    wr(4'h7, 8'h02);
    rd(4'h8, d); check("R4 page2", d, 8'h00);
    wr(4'h7, 8'h50);
    port_connected = 3'b111;
    rd(4'h8, d); check("R4 port5 read", d, 8'h00);
    wr(4'h8, 8'h01);
    check("R4 port5 write ignored", port_disable, 3'b000);
    wr(4'h6, 8'hFF);
    rd(4'h6, d); check("R4 loc6", d, 8'h00);
    wr(4'h7, 8'h00);
    rd(4'hB, d); check("R4 page0 locB", d, 8'h00);
    idle(3);
  endtask

  task automatic t_long();
    logic [7:0] d;
    int n = 0;
    wr(4'h1, 8'hFE);
    rd(4'h1, d); check("R5 bit reads 1", d, 8'hFE);
    while (bus_reset_active && n < RC + 10) begin n++; @(negedge clk); end
    check("R5 duration", n, RC);
    rd(4'h1, d); check("R5 bit cleared", d, 8'hFC);
  endtask

  task automatic t_short();
    logic [7:0] d;
    wr(4'h5, 8'h01);
    check("R6 pulse high", short_reset_req, 1'b1);
    @(negedge clk);
    check("R6 pulse low", short_reset_req, 1'b0);
    rd(4'h5, d); check("R6 bit reads 0", d[0], 1'b0);
  endtask

  task automatic t_flags();
    logic [7:0] d;
    wr(4'h5, 8'h20); idle(2);
    cable_pwr = 0; idle(3);
    rd(4'h5, d); check("R8 fall sets", d[3], 1'b1);
    wr(4'h5, 8'h00);
    rd(4'h5, d); check("R7 write 0 keeps", d[3], 1'b1);
    wr(4'h5, 8'h08);
    rd(4'h5, d); check("R7 write 1 clears", d[3], 1'b0);
    cable_pwr = 1; idle(3);
    rd(4'h5, d); check("R8 rise no set", d[3], 1'b0);
    @(negedge clk); loop_evt = 1; timeout_evt = 1;
    @(negedge clk); loop_evt = 0; timeout_evt = 0;
    rd(4'h5, d); check("R7 loop+timeout set", d[4:2], 3'b101);
    wr(4'h5, 8'h14);
    rd(4'h5, d); check("R7 loop+timeout clear", d[4:2], 3'b000);
  endtask

  task automatic t_port_evt();
    logic [7:0] d;
    wr(4'h5, 8'h20);
    wr(4'h7, 8'h00);
    wr(4'h9, 8'h10);
    port_connected[0] = ~port_connected[0]; idle(3);
    rd(4'h5, d); check("R9 enabled change", d[5], 1'b1);
    wr(4'h5, 8'h20);
    port_bias[2] = 1; idle(3);
    rd(4'h5, d); check("R9 disabled port no event", d[5], 1'b0);
    @(negedge clk); port_fault_evt[0] = 1;
    @(negedge clk); port_fault_evt[0] = 0; idle(2);
    rd(4'h9, d); check("R7 fault set", d[3], 1'b1);
    rd(4'h5, d); check("R9 fault change event", d[5], 1'b1);
    wr(4'h9, 8'h18);
    rd(4'h9, d); check("R7 fault clear", d[3], 1'b0);
    wr(4'h9, 8'h00); idle(3);
    wr(4'h5, 8'h20);
  endtask

  task automatic t_resume();
    logic [7:0] d;
    @(negedge clk); port_resume[1] = 1;
    @(negedge clk); port_resume[1] = 0;
    rd(4'h5, d); check("R10 no enable", d[5], 1'b0);
    wr(4'h5, 8'h02);
    @(negedge clk); port_resume[2] = 1;
    @(negedge clk); port_resume[2] = 0;
    rd(4'h5, d); check("R10 enabled", d[5], 1'b1);
    wr(4'h5, 8'h20);
  endtask

  task automatic t_priority();
    logic [7:0] d;
    @(negedge clk);
    reg_we = 1; reg_addr = 4'h5; reg_wdata = 8'h04; loop_evt = 1;
    @(negedge clk);
    reg_we = 0; loop_evt = 0;
    rd(4'h5, d); check("R11 event wins", d[2], 1'b1);
    wr(4'h5, 8'h04);
    rd(4'h5, d); check("R11 later clear", d[2], 1'b0);
  endtask

  initial begin
    idle(3);
    rst_n = 1;
    idle(2);
    t_reset();
    t_link();
    t_window();
    t_ident();
    t_unimpl();
    t_long();
    t_short();
    t_flags();
    t_port_evt();
    t_resume();
    t_priority();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule